// File: doc/BRIEF.md
# Serial EEPROM Identification Loader

This block runs once after reset. It reads three 16-bit identification words from an external 3-wire serial EEPROM: the vendor ID, the sub-vendor ID and the model number. It holds them as configuration values for the bus logic that exposes them. Its serial clock is the system clock divided by `CLK_DIV`, which defaults to 256.

In the first cycle after reset it samples the chip-select line. That line is pulled up when an EEPROM is fitted. If the line reads low, the block skips the fetch, keeps built-in default IDs and reports completion at once. If it reads high, the block runs one read frame per word:

- chip select high;
- a start bit, a two-bit read opcode and a word address, all MSB first;
- a dummy slot;
- sixteen data bits, MSB first;
- one serial period with chip select low before the next word.

After completion, a 3-bit manual register drives the chip-select, clock and data-in lines directly, so software can bit-bang the device. A 4-bit readback shows the three line states and the data-out pin.

Top module: `ee_autoload`

## Requirements
- R1: During and straight after reset, `ee_cs_o`, `ee_sk_o`, `ee_di_o`, `done_o` and `present_o` are 0, and the three ID outputs hold their default parameters.
- R2: `cs_sense_i` is sampled on the first clock edge after reset release and appears on `present_o`. A 1 starts the automatic fetch in the next cycle.
- R3: During the fetch each serial period lasts `CLK_DIV` system cycles. `ee_sk_o` is low for the first half and high for the second half, and it is high only while `ee_cs_o` is high.
- R4: Each word read holds `ee_cs_o` high for 26 serial periods. On `ee_di_o` the block sends, one bit per period and MSB first: bit 1, then opcode bits 1 and 0, then the 6-bit address. `ee_di_o` is 0 in every other period.
- R5: `ee_di_o` changes only at the start of a serial period, which is the falling edge of the clock, and is stable while `ee_sk_o` is high.
- R6: `ee_do_i` is ignored in the dummy period (period 9, counting from 0). It is sampled in the first system cycle of the high phase of periods 10 to 25, and the bits are assembled MSB first.
- R7: Word address `BASE_ADDR` loads `vendor_id_o`, `BASE_ADDR+1` loads `subvendor_id_o` and `BASE_ADDR+2` loads `model_id_o`. After the fetch the IDs do not change.
- R8: After each word, `ee_cs_o` and `ee_sk_o` stay low for one full serial period.
- R9: `done_o` rises in the first cycle after the gap period of the third word and stays high until reset.
- R10: If `cs_sense_i` was 0, `done_o` rises in the cycle right after sensing. The IDs keep their defaults and the lines never toggle during the load.
- R11: Once `done_o` is high, `man_we_i` loads `man_wdata_i` in one cycle. Bit 0 drives `ee_cs_o`, bit 1 drives `ee_sk_o` and bit 2 drives `ee_di_o`, starting in the next cycle. The manual register resets to 0. `man_rdata_o` bits 0 to 3 show `ee_cs_o`, `ee_sk_o`, `ee_di_o` and `ee_do_i`.
- R12: Manual writes made while `done_o` is 0 have no effect on the lines, either during the fetch or after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_sense_i | input | 1 | Sensed level of the pulled-up chip-select line |
| ee_do_i | input | 1 | Serial data out from the EEPROM |
| man_we_i | input | 1 | Manual register write strobe |
| man_wdata_i | input | 3 | Manual line levels: [0] cs, [1] sk, [2] di |
| ee_cs_o | output | 1 | EEPROM chip select |
| ee_sk_o | output | 1 | EEPROM serial clock |
| ee_di_o | output | 1 | Serial data into the EEPROM |
| man_rdata_o | output | 4 | Readback: [0] cs, [1] sk, [2] di, [3] do |
| present_o | output | 1 | EEPROM detected at reset |
| done_o | output | 1 | Automatic load finished |
| vendor_id_o | output | 16 | Vendor ID |
| subvendor_id_o | output | 16 | Sub-vendor ID |
| model_id_o | output | 16 | Model number |

## Verification
The bench builds the block with `CLK_DIV` = 4 and `BASE_ADDR` = 5. A full three-word fetch then takes 324 cycles, so every cycle of every frame, gap and phase boundary is compared against the reference model. A base address other than zero means an addressing error or a word swap produces the wrong ID. A modelled EEPROM answers only to a correctly formed read command. The bench runs a second reset with no device fitted, and it exercises manual writes both before and after completion.

// File: rtl/ee_autoload_pkg.sv
package ee_autoload_pkg;
  typedef enum logic [1:0] {ST_SENSE = 2'd0, ST_RUN = 2'd1, ST_DONE = 2'd2} ld_state_e;
  localparam int ID_WORDS = 3;
  localparam int DATA_W = 16;
  localparam logic [1:0] OP_READ = 2'b10;
endpackage

// File: rtl/ee_clkdiv.sv
module ee_clkdiv #(
  parameter int CLK_DIV = 256
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic wrap_o,
  output logic mid_o,
  output logic high_o
);
  localparam int CNT_W = $clog2(CLK_DIV);
  localparam int HALF  = CLK_DIV / 2;

  logic [CNT_W-1:0] cnt_q;

  assign wrap_o = en_i && (cnt_q == CNT_W'(CLK_DIV - 1));
  assign mid_o  = en_i && (cnt_q == CNT_W'(HALF));
  assign high_o = (cnt_q >= CNT_W'(HALF));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!en_i)  cnt_q <= '0;
    else if (wrap_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/ee_seq.sv
module ee_seq
  import ee_autoload_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int BASE_ADDR = 0,
  localparam int WORD_W   = $clog2(ID_WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              wrap_i,
  input  logic              mid_i,
  input  logic              high_i,
  output logic              cs_o,
  output logic              sk_o,
  output logic              di_o,
  output logic              sample_o,
  output logic              store_o,
  output logic [WORD_W-1:0] word_o,
  output logic              last_o
);
  localparam int CMD_BITS   = 3 + ADDR_W;
  localparam int DATA_FIRST = CMD_BITS + 1;
  localparam int DATA_LAST  = DATA_FIRST + DATA_W - 1;
  localparam int GAP_BIT    = DATA_LAST + 1;
  localparam int BIT_W      = $clog2(GAP_BIT + 1);

  logic [BIT_W-1:0]    bit_q;
  logic [WORD_W-1:0]   word_q;
  logic [CMD_BITS-1:0] cmd, cmd_sh;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_q  <= '0;
      word_q <= '0;
    end else if (!en_i) begin
      bit_q  <= '0;
      word_q <= '0;
    end else if (wrap_i) begin
      if (bit_q == BIT_W'(GAP_BIT)) begin
        bit_q  <= '0;
        word_q <= word_q + 1'b1;
      end else begin
        bit_q <= bit_q + 1'b1;
      end
    end
  end

  assign cmd    = {1'b1, OP_READ, ADDR_W'(BASE_ADDR + int'(word_q))};
  assign cmd_sh = cmd << bit_q;  // MSB-first walk; zero past the command

  assign cs_o     = en_i && (bit_q < BIT_W'(GAP_BIT));
  assign sk_o     = cs_o && high_i;
  assign di_o     = cs_o && cmd_sh[CMD_BITS-1];
  assign sample_o = mid_i && cs_o && (bit_q >= BIT_W'(DATA_FIRST)) && (bit_q <= BIT_W'(DATA_LAST));
  assign store_o  = wrap_i && (bit_q == BIT_W'(DATA_LAST));
  assign last_o   = wrap_i && (bit_q == BIT_W'(GAP_BIT)) && (word_q == WORD_W'(ID_WORDS - 1));
  assign word_o   = word_q;
endmodule

// File: rtl/ee_capture.sv
module ee_capture
  import ee_autoload_pkg::*;
#(
  parameter logic [DATA_W-1:0] DEF_VENDOR    = 16'h1D0F,
  parameter logic [DATA_W-1:0] DEF_SUBVENDOR = 16'h1D0F,
  parameter logic [DATA_W-1:0] DEF_MODEL     = 16'h0004,
  localparam int WORD_W = $clog2(ID_WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sample_i,
  input  logic              do_i,
  input  logic              store_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [DATA_W-1:0] vendor_o,
  output logic [DATA_W-1:0] subvendor_o,
  output logic [DATA_W-1:0] model_o
);
  localparam logic [ID_WORDS-1:0][DATA_W-1:0] DEFS = {DEF_MODEL, DEF_SUBVENDOR, DEF_VENDOR};

  logic [DATA_W-1:0] shreg_q;
  logic [DATA_W-1:0] id_q [ID_WORDS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       shreg_q <= '0;
    else if (sample_i) shreg_q <= {shreg_q[DATA_W-2:0], do_i};
  end

  for (genvar g = 0; g < ID_WORDS; g++) begin : g_id
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                     id_q[g] <= DEFS[g];
      else if (store_i && (word_i == WORD_W'(g)))      id_q[g] <= shreg_q;
    end
  end

  assign vendor_o    = id_q[0];
  assign subvendor_o = id_q[1];
  assign model_o     = id_q[2];
endmodule

// File: rtl/ee_autoload.sv
module ee_autoload
  import ee_autoload_pkg::*;
#(
  parameter int                CLK_DIV       = 256,
  parameter int                ADDR_W        = 6,
  parameter int                BASE_ADDR     = 0,
  parameter logic [DATA_W-1:0] DEF_VENDOR    = 16'h1D0F,
  parameter logic [DATA_W-1:0] DEF_SUBVENDOR = 16'h1D0F,
  parameter logic [DATA_W-1:0] DEF_MODEL     = 16'h0004
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_sense_i,
  input  logic              ee_do_i,
  input  logic              man_we_i,
  input  logic [2:0]        man_wdata_i,
  output logic              ee_cs_o,
  output logic              ee_sk_o,
  output logic              ee_di_o,
  output logic [3:0]        man_rdata_o,
  output logic              present_o,
  output logic              done_o,
  output logic [DATA_W-1:0] vendor_id_o,
  output logic [DATA_W-1:0] subvendor_id_o,
  output logic [DATA_W-1:0] model_id_o
);
  localparam int WORD_W = $clog2(ID_WORDS);

  ld_state_e         state_q;
  logic              present_q;
  logic [2:0]        man_q;
  logic              run;
  logic              wrap, mid, high;
  logic              seq_cs, seq_sk, seq_di, sample, store, last;
  logic [WORD_W-1:0] word;

  assign run = (state_q == ST_RUN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_SENSE;
      present_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_SENSE: begin
          present_q <= cs_sense_i;
          state_q   <= cs_sense_i ? ST_RUN : ST_DONE;
        end
        ST_RUN:  if (last) state_q <= ST_DONE;
        default: state_q <= ST_DONE;
      endcase
    end
  end

  // manual access only once the fetch has released the lines
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            man_q <= '0;
    else if (man_we_i && state_q == ST_DONE) man_q <= man_wdata_i;
  end

  ee_clkdiv #(.CLK_DIV(CLK_DIV)) i_clkdiv (
    .clk_i, .rst_ni, .en_i(run), .wrap_o(wrap), .mid_o(mid), .high_o(high)
  );

  ee_seq #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) i_seq (
    .clk_i, .rst_ni, .en_i(run), .wrap_i(wrap), .mid_i(mid), .high_i(high),
    .cs_o(seq_cs), .sk_o(seq_sk), .di_o(seq_di), .sample_o(sample),
    .store_o(store), .word_o(word), .last_o(last)
  );

  ee_capture #(
    .DEF_VENDOR(DEF_VENDOR), .DEF_SUBVENDOR(DEF_SUBVENDOR), .DEF_MODEL(DEF_MODEL)
  ) i_capture (
    .clk_i, .rst_ni, .sample_i(sample), .do_i(ee_do_i), .store_i(store), .word_i(word),
    .vendor_o(vendor_id_o), .subvendor_o(subvendor_id_o), .model_o(model_id_o)
  );

  assign done_o      = (state_q == ST_DONE);
  assign present_o   = present_q;
  assign ee_cs_o     = done_o ? man_q[0] : seq_cs;
  assign ee_sk_o     = done_o ? man_q[1] : seq_sk;
  assign ee_di_o     = done_o ? man_q[2] : seq_di;
  assign man_rdata_o = {ee_do_i, ee_di_o, ee_sk_o, ee_cs_o};
endmodule

// File: rtl/ee_autoload_chk.sv
module ee_autoload_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        ee_cs_o,
  input logic        ee_sk_o,
  input logic        ee_di_o,
  input logic        done_o,
  input logic        present_o,
  input logic [15:0] vendor_id_o,
  input logic [15:0] subvendor_id_o,
  input logic [15:0] model_id_o
);
  // R3
  sk_in_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o && ee_sk_o |-> ee_cs_o);

  // R5
  di_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o && ee_sk_o && $past(ee_sk_o) |-> $stable(ee_di_o));

  // R9
  done_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o);

  // R7
  id_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> $stable({vendor_id_o, subvendor_id_o, model_id_o}));

  // R10
  absent_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !present_o && !done_o |-> !ee_cs_o && !ee_sk_o);
endmodule

bind ee_autoload ee_autoload_chk i_chk (.*);

// File: tb/test_ee_autoload.sv
`timescale 1ns/1ps
module test_ee_autoload;
  localparam int D    = 4;
  localparam int BASE = 5;
  localparam int RUN_CYC = 3 * 27 * D;
  localparam logic [15:0] DV = 16'hBEEF, DS = 16'h1234, DM = 16'h0042;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cs_sense = 1'b1;
  logic ee_do = 1'b1;
  logic man_we = 1'b0;
  logic [2:0] man_wdata = '0;
  logic ee_cs, ee_sk, ee_di, present, done;
  logic [3:0] rdata;
  logic [15:0] vid, sid, mid;

  always #2.5 clk = ~clk;

  ee_autoload #(.CLK_DIV(D), .BASE_ADDR(BASE), .DEF_VENDOR(DV), .DEF_SUBVENDOR(DS), .DEF_MODEL(DM))
  i_ee_autoload (
    .clk_i(clk), .rst_ni(rst_ni), .cs_sense_i(cs_sense), .ee_do_i(ee_do),
    .man_we_i(man_we), .man_wdata_i(man_wdata), .ee_cs_o(ee_cs), .ee_sk_o(ee_sk),
    .ee_di_o(ee_di), .man_rdata_o(rdata), .present_o(present), .done_o(done),
    .vendor_id_o(vid), .subvendor_id_o(sid), .model_id_o(mid)
  );

  function automatic logic [15:0] word_of(input logic [5:0] a);
    return 16'hA5C3 ^ ({10'd0, a} * 16'h1111);
  endfunction

  // behavioural EEPROM: answers only a well-formed read
  int ee_n = 0;
  logic [8:0] ee_cmd = '0;
  always @(posedge ee_cs) ee_n = 0;
  always @(posedge ee_sk) if (ee_cs) begin
    if (ee_n < 9) ee_cmd = {ee_cmd[7:0], ee_di};
    ee_n++;
  end
  always @(negedge ee_sk) if (ee_cs) begin
    logic [15:0] w;
    w = word_of(ee_cmd[5:0]);
    if (ee_n == 9) ee_do = 1'b0;
    else if (ee_n >= 10 && ee_n <= 25 && ee_cmd[8:6] == 3'b110) ee_do = w[15-(ee_n-10)];
    else ee_do = 1'b1;
  end

  int checks = 0, errors = 0;
  int k = 0;
  logic exp_present = 1'b1;
  logic [2:0] exp_man = '0;

  task automatic chk(input bit ok, input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s cyc=%0d got %0h exp %0h", req, k, got, exp);
    end
  endtask

  function automatic logic exp_done();
    if (k == 0) return 1'b0;
    return !(exp_present && (k - 1) < RUN_CYC);
  endfunction

  // expected {cs, sk, di}
  function automatic logic [2:0] exp_pins();
    int t, bp, ph, b, f;
    logic [8:0] cmd;
    logic cs, sk, di;
    if (k == 0) return 3'b000;
    if (exp_done()) return {exp_man[0], exp_man[1], exp_man[2]};
    t = k - 1; bp = t / D; ph = t % D; b = bp % 27; f = bp / 27;
    cmd = {1'b1, 2'b10, 6'(BASE + f)};
    cs = (b < 26);
    sk = cs && (ph >= D / 2);
    di = cs && (b < 9) && cmd[8 - b];
    return {cs, sk, di};
  endfunction

  task automatic compare();
    // R3 R4 R5 R8 serial line timing
    chk({ee_cs, ee_sk, ee_di} == exp_pins(), "R3 R4 R5 R8 pins", {ee_cs, ee_sk, ee_di}, exp_pins());
    // R9 done timing
    chk(done == exp_done(), "R9 done", done, exp_done());
  endtask

  task automatic tick();
    logic pre;
    pre = exp_done();
    @(posedge clk);
    k++;
    if (man_we && pre) exp_man = man_wdata;
    @(negedge clk);
    compare();
  endtask

  task automatic do_reset(input logic sense);
    @(negedge clk);
    rst_ni = 1'b0;
    cs_sense = sense;
    exp_present = sense;
    exp_man = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    k = 0;
    // R1 reset state
    chk({ee_cs, ee_sk, ee_di, done, present} == 5'b0, "R1 lines", {ee_cs, ee_sk, ee_di, done, present}, 0);
    chk({vid, sid, mid} == {DV, DS, DM}, "R1 ids", {vid, sid, mid}, {DV, DS, DM});
  endtask

  initial begin
    do_reset(1'b1);
    tick();
    chk(present == 1'b1, "R2 present", present, 1);
    repeat (100) tick();
    // R12 writes during the fetch
    man_we = 1'b1; man_wdata = 3'b111;
    repeat (5) tick();
    man_we = 1'b0;
    while (k < RUN_CYC + 3) tick();
    // R6 R7 captured words
    chk(vid == word_of(6'(BASE)),     "R6 R7 vendor",    vid, word_of(6'(BASE)));
    chk(sid == word_of(6'(BASE + 1)), "R6 R7 subvendor", sid, word_of(6'(BASE + 1)));
    chk(mid == word_of(6'(BASE + 2)), "R6 R7 model",     mid, word_of(6'(BASE + 2)));
    // R12 earlier writes left no trace
    chk(rdata[2:0] == 3'b000, "R12 readback", rdata, 0);
    // R11 manual access
    man_we = 1'b1; man_wdata = 3'b101;
    tick();
    man_we = 1'b0;
    tick();
    chk(rdata == {ee_do, 3'b101}, "R11 readback", rdata, {ee_do, 3'b101});
    man_we = 1'b1; man_wdata = 3'b010;
    tick();
    man_we = 1'b0;
    repeat (2) tick();
    chk(rdata == {ee_do, 3'b010}, "R11 readback2", rdata, {ee_do, 3'b010});
    chk(vid == word_of(6'(BASE)), "R7 hold", vid, word_of(6'(BASE)));

    // R10 no device fitted
    do_reset(1'b0);
    repeat (10) tick();
    chk(present == 1'b0, "R10 present", present, 0);
    chk({vid, sid, mid} == {DV, DS, DM}, "R10 ids", {vid, sid, mid}, {DV, DS, DM});

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule